// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Nesting-Dependent Context Save

This block is the processor-side controller that takes over once the interrupt controller has picked a winning request. It latches the request's priority and compares it in one cycle against the priority of the running task. A request that wins starts an entry sequence: the context phase, a one-cycle acknowledge pulse back to the controller, a vector-table fetch, and finally a one-cycle pulse marking the start of the service routine. The pulse carries the fetched first word. A request that loses, or arrives while entry is disabled or a sequence is running, leaves no trace.

The context phase depends on how deeply interrupts are nested. The first `SHADOW_LEVELS` levels (two by default) switch to shadow registers in a fixed two cycles. Deeper levels write the 16-register context out as four 128-bit beats on a valid/ready write stream. A beat is held stable while `save_ready` is low, and the phase only advances on a handshake. The vector fetch request is also valid/ready: `fetch_addr` is held until `fetch_ready`. The response side has no back-pressure and is taken in the first cycle `rsp_valid` is seen while waiting.

A nesting counter and a small priority stack track the depth. A return pulse restores the priority of the interrupted task. With a shadow level and no stalls, the routine start comes six cycles after the request is sampled. Adding three cycles of arbitration gives nine cycles, or 45 ns at 200 MHz.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `cur_prio` and `nest_depth` are 0 and `ack`, `save_valid`, `fetch_valid` and `isr_start` are low.
- R2: A request sampled in idle with `irq_en` high is compared one cycle later; it is accepted only when `req_prio` is strictly greater than `cur_prio`, otherwise no acknowledge or routine start follows and depth and priority stay unchanged.
- R3: On acceptance, `cur_prio` takes the request priority and `nest_depth` increases by one, visible from the second edge after the request was sampled.
- R4: When the new depth is at most `SHADOW_LEVELS`, no save beat is issued, and `ack` is high for exactly one cycle, three cycles after the sampling edge.
- R5: When the new depth exceeds `SHADOW_LEVELS`, four save beats are issued; beat i (0..3) has address `ctx_ptr + 16*i` and data registers 4i..4i+3, with register 4i in bits 31:0 and each higher register in the next 32 bits. With `save_ready` high, `ack` follows five cycles after the sampling edge.
- R6: While `save_valid` is high and `save_ready` is low, the beat's address and data are held, and every stalled cycle delays `ack` by one cycle.
- R7: `fetch_valid` rises in the cycle after `ack` with `fetch_addr = vec_base + (accepted priority << ENTRY_SHIFT)`, with `ENTRY_SHIFT` = 5 by default, and is held until `fetch_ready` is high.
- R8: `isr_start` pulses for one cycle in the cycle after `rsp_valid` is seen in the response wait, with `isr_word` equal to that `rsp_data`; `rsp_valid` at any other time does nothing.
- R9: `ret_pulse` in idle with a nonzero depth decrements `nest_depth` and restores the priority held before the matching entry; at depth 0 it is ignored.
- R10: Requests are ignored while `irq_en` is low or an entry sequence is running, and `ret_pulse` is ignored while a sequence is running.
- R11: When `nest_depth` equals `MAX_NEST`, every request is rejected and the depth never exceeds `MAX_NEST`.
- R12: For a shadow level with no stalls, `isr_start` appears six cycles after the request's sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_en | input | 1 | Global interrupt enable |
| req_valid | input | 1 | Arbitrated request present |
| req_prio | input | PRIO_W | Priority of the arbitrated request |
| ret_pulse | input | 1 | Return from the current service routine |
| ctx_ptr | input | ADDR_W | Context-area pointer for save beats |
| vec_base | input | ADDR_W | Vector table base address |
| ctx_regs | input | NREG*REG_W | Live register context, register 0 in the low bits |
| save_valid | output | 1 | Save beat valid |
| save_ready | input | 1 | Save beat accepted by memory |
| save_addr | output | ADDR_W | Save beat byte address |
| save_data | output | BUS_W | Save beat data |
| ack | output | 1 | One-cycle acknowledge to the interrupt controller |
| fetch_valid | output | 1 | Vector fetch request valid |
| fetch_ready | input | 1 | Vector fetch request accepted |
| fetch_addr | output | ADDR_W | Vector entry address |
| rsp_valid | input | 1 | Vector fetch data valid |
| rsp_data | input | INSTR_W | Vector fetch data |
| isr_start | output | 1 | One-cycle service routine start pulse |
| isr_word | output | INSTR_W | First routine word captured from the response |
| cur_prio | output | PRIO_W | Priority of the running task |
| nest_depth | output | $clog2(MAX_NEST+1) | Current nesting depth |

## Verification
The save-beat hold property assumes `ctx_regs` stays constant while a beat is stalled, because the beat data is taken live from it. The bench holds the context pattern fixed for the whole run. The fetch and acknowledge properties assume that the memory returns `rsp_valid` only after a fetch handshake, with at most stray pulses in idle. The bench's memory model answers one cycle after each handshake, and its stray pulses are injected only while the block is idle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRI,
    S_SWITCH,
    S_SAVE,
    S_ACK,
    S_VREQ,
    S_VRSP
  } seq_state_e;
endpackage

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int PRIO_W   = 8,
  parameter int MAX_NEST = 8,
  parameter int DEPTH_W  = $clog2(MAX_NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [PRIO_W-1:0]  push_prio,
  output logic [PRIO_W-1:0]  cur_prio,
  output logic [DEPTH_W-1:0] depth,
  output logic               full,
  output logic               empty
);
  localparam int IDX_W = (MAX_NEST > 1) ? $clog2(MAX_NEST) : 1;

  logic [PRIO_W-1:0]  saved [MAX_NEST];
  logic [DEPTH_W-1:0] depth_m1;
  logic [IDX_W-1:0]   wr_idx;
  logic [IDX_W-1:0]   rd_idx;

  assign full     = (depth == DEPTH_W'(MAX_NEST));
  assign empty    = (depth == '0);
  assign depth_m1 = depth - 1'b1;
  assign wr_idx   = depth[IDX_W-1:0];
  assign rd_idx   = depth_m1[IDX_W-1:0];

  // previous task priority goes onto the stack
  always_ff @(posedge clk) begin
    if (push && !full) saved[wr_idx] <= cur_prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio <= '0;
      depth    <= '0;
    end else if (push && !full) begin
      cur_prio <= push_prio;
      depth    <= depth + 1'b1;
    end else if (pop && !empty) begin
      cur_prio <= saved[rd_idx];
      depth    <= depth_m1;
    end
  end
endmodule

// File: rtl/irq_save_beats.sv
module irq_save_beats #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              advance,
  output logic [$clog2(BEATS)-1:0] beat_idx,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              last
);
  localparam int BIDX_W = $clog2(BEATS);

  assign last = (beat_idx == BIDX_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_idx  <= '0;
      beat_addr <= '0;
    end else if (start) begin
      beat_idx  <= '0;
      beat_addr <= base_addr;
    end else if (advance) begin
      beat_idx  <= beat_idx + 1'b1;
      beat_addr <= beat_addr + ADDR_W'(BEAT_BYTES);
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int PRIO_W        = 8,
  parameter int ADDR_W        = 32,
  parameter int NREG          = 16,
  parameter int REG_W         = 32,
  parameter int BUS_W         = 128,
  parameter int INSTR_W       = 32,
  parameter int MAX_NEST      = 8,
  parameter int SHADOW_LEVELS = 2,
  parameter int SWITCH_CYC    = 2,
  parameter int ENTRY_SHIFT   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            irq_en,
  input  logic                            req_valid,
  input  logic [PRIO_W-1:0]               req_prio,
  input  logic                            ret_pulse,
  input  logic [ADDR_W-1:0]               ctx_ptr,
  input  logic [ADDR_W-1:0]               vec_base,
  input  logic [NREG*REG_W-1:0]           ctx_regs,
  output logic                            save_valid,
  input  logic                            save_ready,
  output logic [ADDR_W-1:0]               save_addr,
  output logic [BUS_W-1:0]                save_data,
  output logic                            ack,
  output logic                            fetch_valid,
  input  logic                            fetch_ready,
  output logic [ADDR_W-1:0]               fetch_addr,
  input  logic                            rsp_valid,
  input  logic [INSTR_W-1:0]              rsp_data,
  output logic                            isr_start,
  output logic [INSTR_W-1:0]              isr_word,
  output logic [PRIO_W-1:0]               cur_prio,
  output logic [$clog2(MAX_NEST+1)-1:0]   nest_depth
);
  localparam int DEPTH_W    = $clog2(MAX_NEST + 1);
  localparam int BEATS      = (NREG * REG_W) / BUS_W;
  localparam int BEAT_BYTES = BUS_W / 8;
  localparam int BIDX_W     = $clog2(BEATS);
  localparam int SW_W       = $clog2(SWITCH_CYC + 1);

  seq_state_e          state;
  logic [PRIO_W-1:0]   pend_prio;
  logic [ADDR_W-1:0]   vec_q;
  logic [SW_W-1:0]     sw_cnt;
  logic                win;
  logic                push;
  logic                pop;
  logic                deep;
  logic                full;
  logic                empty;
  logic [BIDX_W-1:0]   beat_idx;
  logic                beat_last;
  logic                beat_adv;
  logic [BUS_W-1:0]    slice [BEATS];

  // context slices, one per save beat
  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    assign slice[g] = ctx_regs[g*BUS_W +: BUS_W];
  end

  assign win      = (pend_prio > cur_prio) && !full;
  assign push     = (state == S_PRI) && win;
  assign pop      = (state == S_IDLE) && ret_pulse && !empty;
  assign deep     = (nest_depth >= DEPTH_W'(SHADOW_LEVELS));
  assign beat_adv = (state == S_SAVE) && save_ready;

  irq_prio_stack #(
    .PRIO_W  (PRIO_W),
    .MAX_NEST(MAX_NEST),
    .DEPTH_W (DEPTH_W)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_prio(pend_prio),
    .cur_prio (cur_prio),
    .depth    (nest_depth),
    .full     (full),
    .empty    (empty)
  );

  irq_save_beats #(
    .ADDR_W    (ADDR_W),
    .BEATS     (BEATS),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (push),
    .base_addr(ctx_ptr),
    .advance  (beat_adv),
    .beat_idx (beat_idx),
    .beat_addr(save_addr),
    .last     (beat_last)
  );

  assign save_valid  = (state == S_SAVE);
  assign save_data   = slice[beat_idx];
  assign ack         = (state == S_ACK);
  assign fetch_valid = (state == S_VREQ);
  assign fetch_addr  = vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pend_prio <= '0;
      vec_q     <= '0;
      sw_cnt    <= '0;
      isr_start <= 1'b0;
      isr_word  <= '0;
    end else begin
      isr_start <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (irq_en && req_valid) begin
            pend_prio <= req_prio;
            state     <= S_PRI;
          end
        end
        S_PRI: begin
          if (win) begin
            vec_q  <= vec_base + (ADDR_W'(pend_prio) << ENTRY_SHIFT);
            sw_cnt <= '0;
            state  <= deep ? S_SAVE : S_SWITCH;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SWITCH: begin
          sw_cnt <= sw_cnt + 1'b1;
          if (sw_cnt == SW_W'(SWITCH_CYC - 1)) state <= S_ACK;
        end
        S_SAVE: begin
          if (save_ready && beat_last) state <= S_ACK;
        end
        S_ACK: state <= S_VREQ;
        S_VREQ: begin
          if (fetch_ready) state <= S_VRSP;
        end
        S_VRSP: begin
          if (rsp_valid) begin
            isr_word  <= rsp_data;
            isr_start <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int PRIO_W        = 8,
  parameter int ADDR_W        = 32,
  parameter int BUS_W         = 128,
  parameter int DEPTH_W       = 4,
  parameter int MAX_NEST      = 8,
  parameter int SHADOW_LEVELS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack,
  input logic               save_valid,
  input logic               save_ready,
  input logic [ADDR_W-1:0]  save_addr,
  input logic [BUS_W-1:0]   save_data,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               isr_start,
  input logic [PRIO_W-1:0]  cur_prio,
  input logic [DEPTH_W-1:0] nest_depth
);
  localparam logic [DEPTH_W-1:0] LIM_NEST = DEPTH_W'(MAX_NEST);
  localparam logic [DEPTH_W-1:0] LIM_SHAD = DEPTH_W'(SHADOW_LEVELS);

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_shadow_nosave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    save_valid |-> (nest_depth > LIM_SHAD));

  p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, save_valid, fetch_valid}));

  p_save_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid && !save_ready) |=> (save_valid && $stable(save_addr) && $stable(save_data)));

  p_fetch_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> fetch_valid);

  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isr_start |=> !isr_start);

  p_prio_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (save_valid || ack || fetch_valid) |=> $stable(cur_prio) && $stable(nest_depth));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= LIM_NEST);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .PRIO_W       (PRIO_W),
  .ADDR_W       (ADDR_W),
  .BUS_W        (BUS_W),
  .DEPTH_W      (DEPTH_W),
  .MAX_NEST     (MAX_NEST),
  .SHADOW_LEVELS(SHADOW_LEVELS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .save_valid (save_valid),
  .save_ready (save_ready),
  .save_addr  (save_addr),
  .save_data  (save_data),
  .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready),
  .fetch_addr (fetch_addr),
  .isr_start  (isr_start),
  .cur_prio   (cur_prio),
  .nest_depth (nest_depth)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int MAXN = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         irq_en = 1'b1;
  logic         req_valid = 1'b0;
  logic [7:0]   req_prio = '0;
  logic         ret_pulse = 1'b0;
  logic [31:0]  ctx_ptr = 32'h0002_0400;
  logic [31:0]  vec_base = 32'h8000_1000;
  logic [511:0] ctx_regs;
  logic         save_valid, save_ready = 1'b1;
  logic [31:0]  save_addr;
  logic [127:0] save_data;
  logic         ack, fetch_valid, fetch_ready = 1'b1;
  logic [31:0]  fetch_addr;
  logic         rsp_valid = 1'b0;
  logic [31:0]  rsp_data = '0;
  logic         stray = 1'b0;
  logic         isr_start;
  logic [31:0]  isr_word;
  logic [7:0]   cur_prio;
  logic [2:0]   nest_depth;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_entry_seq #(.MAX_NEST(MAXN)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .req_valid(req_valid),
    .req_prio(req_prio), .ret_pulse(ret_pulse), .ctx_ptr(ctx_ptr),
    .vec_base(vec_base), .ctx_regs(ctx_regs), .save_valid(save_valid),
    .save_ready(save_ready), .save_addr(save_addr), .save_data(save_data),
    .ack(ack), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .isr_start(isr_start), .isr_word(isr_word), .cur_prio(cur_prio),
    .nest_depth(nest_depth)
  );

  // vector memory: answers one cycle after each fetch handshake
  always @(posedge clk) begin
    rsp_valid <= (fetch_valid && fetch_ready) || stray;
    rsp_data  <= fetch_addr ^ 32'h5A5A_A5A5;
  end

  function automatic logic [31:0] reg_val(input int r);
    return 32'hC0DE_0000 + 32'(r);
  endfunction

  function automatic logic [127:0] beat_exp(input int i);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = reg_val(4*i + k);
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // vector table: op (1 = return), enable, priority, accept, depth after, priority after
  typedef struct packed {
    logic       is_ret;
    logic       ie;
    logic [7:0] prio;
    logic       acc;
    logic [2:0] dep;
    logic [7:0] cur;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 8'd5,  1'b1, 3'd1, 8'd5},   // R2 R3 first accept
    '{1'b0, 1'b1, 8'd5,  1'b0, 3'd1, 8'd5},   // R2 equal loses
    '{1'b0, 1'b1, 8'd3,  1'b0, 3'd1, 8'd5},   // R2 lower loses
    '{1'b0, 1'b0, 8'd9,  1'b0, 3'd1, 8'd5},   // R10 disabled
    '{1'b0, 1'b1, 8'd9,  1'b1, 3'd2, 8'd9},   // R4 second shadow level
    '{1'b0, 1'b1, 8'd12, 1'b1, 3'd3, 8'd12},  // R5 deep
    '{1'b0, 1'b1, 8'd20, 1'b1, 3'd4, 8'd20},  // R5 deep
    '{1'b0, 1'b1, 8'd30, 1'b0, 3'd4, 8'd20},  // R11 full
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd3, 8'd12},  // R9
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd2, 8'd9},
    '{1'b0, 1'b1, 8'd10, 1'b1, 3'd3, 8'd10},
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd2, 8'd9},
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd1, 8'd5},
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd0, 8'd0},
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd0, 8'd0},   // R9 ignored at depth 0
    '{1'b0, 1'b1, 8'd1,  1'b1, 3'd1, 8'd1},
    '{1'b1, 1'b1, 8'd0,  1'b0, 3'd0, 8'd0}
  };

  task automatic do_ret();
    ret_pulse = 1'b1;
    @(negedge clk);
    ret_pulse = 1'b0;
  endtask

  // drive one request and watch the sequence; j counts edges after sampling
  task automatic do_req(input logic ie, input logic [7:0] prio, input bit exp_acc,
                        input bit deep, input int ss, input int fs, input bit poke);
    int ack_j = -1, fv_j = -1, st_j = -1, beats = 0;
    int sleft = ss, fleft = fs;
    logic [31:0] exp_va;
    exp_va = vec_base + ({24'd0, prio} << 5);
    irq_en = ie; req_valid = 1'b1; req_prio = prio;
    @(negedge clk);
    req_valid = 1'b0; irq_en = 1'b1;
    for (int j = 0; j < 30; j++) begin
      if (ack && ack_j < 0) ack_j = j;
      if (fetch_valid && fv_j < 0) begin
        fv_j = j;
        chk("R7 vector address", 128'(fetch_addr), 128'(exp_va));
      end
      if (isr_start && st_j < 0) begin
        st_j = j;
        chk("R8 routine word", 128'(isr_word), 128'(exp_va ^ 32'h5A5A_A5A5));
      end
      if (save_valid) begin
        if (sleft > 0) begin
          save_ready = 1'b0; sleft--;
        end else begin
          save_ready = 1'b1;
          chk("R5 beat address", 128'(save_addr), 128'(ctx_ptr + 32'(16 * beats)));
          chk("R5 beat data", save_data, beat_exp(beats));
          beats++;
        end
      end else save_ready = 1'b1;
      if (fetch_valid && fleft > 0) begin
        fetch_ready = 1'b0; fleft--;
      end else fetch_ready = 1'b1;
      if (poke && j == 2) begin
        req_valid = 1'b1; req_prio = 8'hFF; ret_pulse = 1'b1;
      end else begin
        req_valid = 1'b0; ret_pulse = 1'b0;
      end
      @(negedge clk);
    end
    if (exp_acc) begin
      chk(deep ? "R5 R6 ack cycle" : "R4 ack cycle", 128'(ack_j),
          128'((deep ? 5 : 3) + ss));
      chk("R7 fetch after ack", 128'(fv_j), 128'(ack_j + 1));
      chk("R8 start cycle", 128'(st_j), 128'(ack_j + 3 + fs));
      chk(deep ? "R5 beat count" : "R4 no beats", 128'(beats), 128'(deep ? 4 : 0));
      if (!deep && fs == 0) chk("R12 six cycle entry", 128'(st_j), 128'(6));
    end else begin
      chk("R2 R10 R11 no ack", 128'(ack_j), 128'(-1));
      chk("R2 R10 R11 no start", 128'(st_j), 128'(-1));
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) ctx_regs[r*32 +: 32] = reg_val(r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 depth", 128'(nest_depth), 128'(0));
    chk("R1 priority", 128'(cur_prio), 128'(0));
    chk("R1 outputs idle", 128'({ack, save_valid, fetch_valid, isr_start}), 128'(0));

    for (int v = 0; v < NV; v++) begin
      if (VT[v].is_ret) do_ret();
      else do_req(VT[v].ie, VT[v].prio, VT[v].acc, VT[v].dep > 3'd2, 0, 0, 1'b0);
      chk("R3 R9 depth after step", 128'(nest_depth), 128'(VT[v].dep));
      chk("R3 R9 priority after step", 128'(cur_prio), 128'(VT[v].cur));
    end

    // R8 stray responses in idle are ignored
    stray = 1'b1;
    repeat (3) @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk("R8 stray response", 128'(isr_start), 128'(0));

    // back-pressure on a deep entry, with a request and return poked mid-sequence
    do_req(1'b1, 8'd4, 1'b1, 1'b0, 0, 0, 1'b0);
    do_req(1'b1, 8'd6, 1'b1, 1'b0, 0, 2, 1'b0);
    do_req(1'b1, 8'd8, 1'b1, 1'b1, 3, 2, 1'b1);
    chk("R10 busy request and return ignored depth", 128'(nest_depth), 128'(3));
    chk("R10 busy request ignored priority", 128'(cur_prio), 128'(8));
    do_ret();
    chk("R9 restore", 128'(cur_prio), 128'(6));
    do_ret();
    do_ret();
    chk("R9 back to zero", 128'(nest_depth), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule